// File: doc/BRIEF.md
# Dual PLL clock source controller

This block holds the settings for two clock generators that can each drive a processor core. Software programs each generator's frequency range and multiplier through one 32-bit register. It also picks whether the first generator takes its settings from board strap pins or from register fields, and it picks which generator clocks the core. The low register bits always reflect the strap pins as they are now.

Changing the select bit starts a handover that does not need a reset. The block first turns off the gate enable of the old source. It leaves both gates off for one cycle, then turns on the gate of the new source. The new source must report lock and must not be programmed to clock-off; if either condition fails, the handover waits and the status bit keeps showing the old source. The analog generators sit outside the block. They are seen only through their lock inputs and the gate enables that the block drives.

Top module: `dual_pll_ctrl`

## Requirements
- R1: The source-0 configuration outputs follow the strap pins while register bit 9 is 0. While bit 9 is 1, they take the multiplier from bits [14:10] and the range from bits [16:15].
- R2: The source-1 configuration outputs always come from register bits [21:17] (multiplier) and [23:22] (range). The strap pins never affect them.
- R3: Bits 7, 9 to 23 read back what was last written to them. Bits 24 to 31 always read zero.
- R4: After reset, every writable bit is zero. Source 0 drives the core (clk_en_o = 01, clk_sel_o = 0) and takes its settings from the pins. Source 1 has multiplier 0, which means clock-off, and range 00, which means medium.
- R5: A write that makes bit 7 differ from the active source starts a handover, provided the target is locked and has a nonzero multiplier. clk_en_o becomes 00 after the next clock edge. On the edge after that, clk_sel_o and status bit 8 show the new source. The whole handover fits within three cycles of the write.
- R6: The two gate enables are never both on. Between turning off one source and turning on the other, both are off for exactly one cycle.
- R7: While the target source has its lock input low or its multiplier at zero, the handover waits and the status bit shows the old source. The handover starts once both conditions hold.
- R8: Bits [4:0] always read the live multiplier pins and bits [6:5] the live range pins. Writes to bits 0 to 6 and to status bit 8 have no effect.
- R9: Writing bit 7 to 0 while source 1 is active returns the core to source 0, using the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data (always valid) |
| pin_mult_i | input | 5 | Strap pins, source-0 multiplier |
| pin_range_i | input | 2 | Strap pins, source-0 range |
| lock_i | input | 2 | Lock flags, bit n for source n |
| pll0_mult_o | output | 5 | Effective source-0 multiplier |
| pll0_range_o | output | 2 | Effective source-0 range |
| pll1_mult_o | output | 5 | Source-1 multiplier (0 = clock-off) |
| pll1_range_o | output | 2 | Source-1 range (00 = medium) |
| clk_en_o | output | 2 | Glitch-free gate enables, bit n for source n |
| clk_sel_o | output | 1 | Source currently driving the core |

## Verification
The hardest case to reach is a handover request that sits waiting on a target that is programmed but not yet locked. That needs a lock input that reacts to the block's own configuration outputs. The bench therefore models each generator with a stub that drops lock for a fixed number of cycles whenever that generator's settings change. It then requests the switch in the write that follows the reprogramming. The bench confirms that the select stays put while lock is low, and that the gap-then-enable sequence follows within two edges of lock returning.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int REG_W     = 32;
  localparam int MULT_W    = 5;
  localparam int RANGE_W   = 2;
  localparam int PIN_W     = MULT_W + RANGE_W;
  localparam int SEL_BIT   = PIN_W;
  localparam int STAT_BIT  = PIN_W + 1;
  localparam int P0INT_BIT = PIN_W + 2;
  localparam int P0M_LSB   = P0INT_BIT + 1;
  localparam int P0R_LSB   = P0M_LSB + MULT_W;
  localparam int P1M_LSB   = P0R_LSB + RANGE_W;
  localparam int P1R_LSB   = P1M_LSB + MULT_W;
  localparam int NUM_SRC   = 2;

  typedef struct packed {
    logic [MULT_W-1:0]  mult;
    logic [RANGE_W-1:0] range;
  } pll_cfg_t;

  typedef enum logic {SW_IDLE, SW_GAP} sw_state_e;
endpackage

// File: rtl/dpll_cfg_regs.sv
module dpll_cfg_regs
  import dpll_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  pll_cfg_t         pin_cfg_i,
  input  logic             active_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             sel_req_o,
  output pll_cfg_t         pll0_cfg_o,
  output pll_cfg_t         pll1_cfg_o
);
  logic     sel_q, p0int_q;
  pll_cfg_t p0_q, p1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      p0int_q <= 1'b0;
      p0_q    <= '0;
      p1_q    <= '0;
    end else if (wr_en_i) begin
      sel_q      <= wr_data_i[SEL_BIT];
      p0int_q    <= wr_data_i[P0INT_BIT];
      p0_q.mult  <= wr_data_i[P0M_LSB +: MULT_W];
      p0_q.range <= wr_data_i[P0R_LSB +: RANGE_W];
      p1_q.mult  <= wr_data_i[P1M_LSB +: MULT_W];
      p1_q.range <= wr_data_i[P1R_LSB +: RANGE_W];
    end
  end

  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[MULT_W-1:0]            = pin_cfg_i.mult;
    rd_data_o[MULT_W +: RANGE_W]     = pin_cfg_i.range;
    rd_data_o[SEL_BIT]               = sel_q;
    rd_data_o[STAT_BIT]              = active_i;
    rd_data_o[P0INT_BIT]             = p0int_q;
    rd_data_o[P0M_LSB +: MULT_W]     = p0_q.mult;
    rd_data_o[P0R_LSB +: RANGE_W]    = p0_q.range;
    rd_data_o[P1M_LSB +: MULT_W]     = p1_q.mult;
    rd_data_o[P1R_LSB +: RANGE_W]    = p1_q.range;
  end

  assign sel_req_o  = sel_q;
  assign pll0_cfg_o = p0int_q ? p0_q : pin_cfg_i;
  assign pll1_cfg_o = p1_q;

  AST_WR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> sel_req_o == $past(wr_data_i[SEL_BIT])); // R3
endmodule

// File: rtl/dpll_clk_switch.sv
module dpll_clk_switch
  import dpll_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_req_i,
  input  logic [NUM_SRC-1:0] lock_i,
  input  logic [NUM_SRC-1:0] src_on_i,
  output logic [NUM_SRC-1:0] clk_en_o,
  output logic               active_o
);
  sw_state_e state_q;
  logic      target, go;

  assign target = ~active_o;
  // new source must be locked and not programmed to clock-off
  assign go = (sel_req_i != active_o) && lock_i[target] && src_on_i[target];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SW_IDLE;
      active_o <= 1'b0;
      clk_en_o <= 2'b01;
    end else begin
      case (state_q)
        SW_IDLE: if (go) begin
          state_q  <= SW_GAP;
          clk_en_o <= '0;
        end
        SW_GAP: begin
          state_q  <= SW_IDLE;
          active_o <= target;
          clk_en_o <= target ? 2'b10 : 2'b01;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  AST_EN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clk_en_o)); // R6
  AST_BREAK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o != '0 && $past(clk_en_o) != '0) |-> clk_en_o == $past(clk_en_o)); // R6
  AST_GAP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SW_GAP |=> state_q == SW_IDLE && clk_en_o != '0); // R5
  AST_LOCK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o[1]) |-> $past(lock_i[1], 2) && $past(src_on_i[1], 2)); // R7
endmodule

// File: rtl/dual_pll_ctrl.sv
module dual_pll_ctrl
  import dpll_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [MULT_W-1:0]  pin_mult_i,
  input  logic [RANGE_W-1:0] pin_range_i,
  input  logic [NUM_SRC-1:0] lock_i,
  output logic [MULT_W-1:0]  pll0_mult_o,
  output logic [RANGE_W-1:0] pll0_range_o,
  output logic [MULT_W-1:0]  pll1_mult_o,
  output logic [RANGE_W-1:0] pll1_range_o,
  output logic [NUM_SRC-1:0] clk_en_o,
  output logic               clk_sel_o
);
  pll_cfg_t pin_cfg, p0_cfg, p1_cfg;
  logic     sel_req, active;
  logic [NUM_SRC-1:0] src_on;

  assign pin_cfg.mult  = pin_mult_i;
  assign pin_cfg.range = pin_range_i;

  dpll_cfg_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .pin_cfg_i(pin_cfg), .active_i(active), .rd_data_o(rd_data_o),
    .sel_req_o(sel_req), .pll0_cfg_o(p0_cfg), .pll1_cfg_o(p1_cfg)
  );

  assign src_on = {p1_cfg.mult != '0, p0_cfg.mult != '0};

  dpll_clk_switch u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_req_i(sel_req), .lock_i(lock_i),
    .src_on_i(src_on), .clk_en_o(clk_en_o), .active_o(active)
  );

  assign pll0_mult_o  = p0_cfg.mult;
  assign pll0_range_o = p0_cfg.range;
  assign pll1_mult_o  = p1_cfg.mult;
  assign pll1_range_o = p1_cfg.range;
  assign clk_sel_o    = active;
endmodule

// File: tb/dual_pll_ctrl_test.sv
module dual_pll_ctrl_test;
  localparam int LOCK_DLY = 16;
  localparam logic [31:0] WMASK = 32'h00FF_FE80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [4:0] pin_mult = 5'd8;
  logic [1:0] pin_range = 2'd1;
  logic [1:0] lock, clk_en;
  logic [4:0] p0m, p1m;
  logic [1:0] p0r, p1r;
  logic sel;
  int n_chk = 0, n_fail = 0;
  logic [31:0] shadow = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dual_pll_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pin_mult_i(pin_mult), .pin_range_i(pin_range),
    .lock_i(lock), .pll0_mult_o(p0m), .pll0_range_o(p0r),
    .pll1_mult_o(p1m), .pll1_range_o(p1r), .clk_en_o(clk_en), .clk_sel_o(sel)
  );

  // lock stubs: lock drops for LOCK_DLY cycles after any config change
  logic [6:0] cur0, cur1, prv0, prv1;
  logic [7:0] cnt0, cnt1;
  assign cur0 = {p0m, p0r};
  assign cur1 = {p1m, p1r};
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv0 <= cur0; prv1 <= cur1; cnt0 <= '0; cnt1 <= '0;
    end else begin
      prv0 <= cur0; prv1 <= cur1;
      if (cur0 != prv0) cnt0 <= 8'(LOCK_DLY); else if (cnt0 != 0) cnt0 <= cnt0 - 8'd1;
      if (cur1 != prv1) cnt1 <= 8'(LOCK_DLY); else if (cnt1 != 0) cnt1 <= cnt1 - 8'd1;
    end
  end
  assign lock[0] = (cnt0 == 0) && (cur0 == prv0) && (p0m != 0);
  assign lock[1] = (cnt1 == 0) && (cur1 == prv1) && (p1m != 0);

  function automatic logic [31:0] exp_rd(logic [31:0] sh, logic st, logic [4:0] pm, logic [1:0] pr);
    return (sh & WMASK) | (32'(st) << 8) | (32'(pr) << 5) | 32'(pm);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    shadow = d & WMASK;
  endtask

  task automatic chk_cfg(string req);
    chk({req, " p0 mult"}, 32'(p0m), shadow[9] ? 32'(shadow[14:10]) : 32'(pin_mult));
    chk({req, " p0 range"}, 32'(p0r), shadow[9] ? 32'(shadow[16:15]) : 32'(pin_range));
    chk({req, " p1 mult"}, 32'(p1m), 32'(shadow[21:17]));
    chk({req, " p1 range"}, 32'(p1r), 32'(shadow[23:22]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 rd", rd_data, 32'h0000_0028);
    chk("R4 en", 32'(clk_en), 32'h1);
    chk("R4 sel", 32'(sel), 32'h0);
    chk("R4 p1 off", 32'(p1m), 32'h0);
    chk("R4 p1 medium", 32'(p1r), 32'h0);
    chk("R1 p0 pins", 32'(p0m), 32'd8);
    // R8 live pins
    pin_mult = 5'd3; pin_range = 2'd2; #1;
    chk("R8 live pins", rd_data, 32'h0000_0043);
    chk("R1 pin follow", 32'(p0m), 32'd3);
    // R8 writes to read-only bits ignored, R3 reserved reads zero
    wr(32'hFFFF_FF7F);
    chk("R8 R3 ro ignore", rd_data, exp_rd(shadow, 1'b0, pin_mult, pin_range));
    chk("R1 internal mult", 32'(p0m), 32'd31);
    chk("R2 pins no effect", 32'(p1m), 32'd31);
    // random field programming, select held at source 0
    for (int i = 0; i < 200; i++) begin
      pin_mult = 5'($urandom); pin_range = 2'($urandom);
      wr($urandom & ~32'h80);
      chk("R3 readback", rd_data, exp_rd(shadow, 1'b0, pin_mult, pin_range));
      chk_cfg("R1 R2 cfg");
      chk("R5 no switch", 32'(sel), 32'h0);
    end
    pin_mult = 5'd8; pin_range = 2'd1;
    // R7 deferral: target clock-off
    wr(32'h0000_0080);
    repeat (10) @(negedge clk);
    chk("R7 clock-off sel", 32'(sel), 32'h0);
    chk("R7 clock-off en", 32'(clk_en), 32'h1);
    chk("R7 clock-off status", rd_data, exp_rd(shadow, 1'b0, pin_mult, pin_range));
    // R7 deferral: target not yet locked after reprogramming
    d = (32'd6 << 17) | (32'd2 << 22);
    wr(d);
    wr(d | 32'h80);
    chk("R7 unlocked", 32'(lock[1]), 32'h0);
    held = 1'b1;
    for (int i = 0; i < 100 && !lock[1]; i++) begin
      if (sel !== 1'b0 || clk_en !== 2'b01) held = 1'b0;
      @(negedge clk);
    end
    chk("R7 held while unlocked", 32'(held), 32'h1);
    chk("R7 lock returned", 32'(lock[1]), 32'h1);
    @(negedge clk);
    chk("R6 gap after lock", 32'(clk_en), 32'h0);
    @(negedge clk);
    chk("R5 R7 en new", 32'(clk_en), 32'h2);
    chk("R5 R7 sel new", 32'(sel), 32'h1);
    chk("R5 status bit", rd_data, exp_rd(shadow, 1'b1, pin_mult, pin_range));
    // R9 switch back to source 0 with both locked
    wr(d);
    chk("R9 old still on", 32'(clk_en), 32'h2);
    @(negedge clk);
    chk("R6 R9 gap", 32'(clk_en), 32'h0);
    @(negedge clk);
    chk("R9 en back", 32'(clk_en), 32'h1);
    chk("R9 sel back", 32'(sel), 32'h0);
    chk("R9 status", rd_data, exp_rd(shadow, 1'b0, pin_mult, pin_range));
    // R5 direct switch within three cycles
    wr(d | 32'h80);
    @(negedge clk);
    chk("R5 R6 gap", 32'(clk_en), 32'h0);
    @(negedge clk);
    chk("R5 en", 32'(clk_en), 32'h2);
    chk("R5 sel", 32'(sel), 32'h1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule